// File: doc/BRIEF.md
# Net Address ROM Function Layer

This block carries out the network-selection step of a single-contact serial slave device. After every bus reset it waits for a one-byte ROM command from the bit layer. Depending on that command, it selects the device at once, sends its 64-bit network address, compares an address sent by the master, or takes part in a bitwise arbitration that lets the master find every device on a shared line. When the device ends up selected, control passes to the function-command layer through a level output. When it ends up deselected, the block stays silent until the next bus reset.

The 64-bit address is a constant input. Its low byte is a family code, the next 48 bits are a serial number and the top byte is a CRC-8 check byte. The block reports whether the check byte agrees with the lower 56 bits. It also exports a serial CRC-8 engine that other layers use for their own transfers.

The bit layer presents one strobe per master write slot, carrying the bit that was written, and one strobe per master read slot. The bit the device answers with is on `tx_bit` in the cycle the read strobe is high. A 1 on `tx_bit` means the line is released.

Top module: `netaddr_rom_layer`

## Requirements
- R1: After `rst_n` low, or one cycle after `bus_reset` high, the block waits for a ROM command, `func_sel` is 0 and `tx_bit` is 1 (released).
- R2: Command bytes arrive least significant bit first on write strobes. Command CCh sets `func_sel` to 1 right after its eighth bit, with no address transfer.
- R3: Command 33h answers the next 64 read slots with `net_addr` bit 0 first up to bit 63, then sets `func_sel`.
- R4: Command 55h compares the next 64 written bits with `net_addr`, bit 0 first. If all of them agree, `func_sel` is set after the 64th bit.
- R5: Under 55h, the first written bit that differs deselects the device. `func_sel` then stays 0, later write slots have no effect and read slots return 1 until a bus reset.
- R6: Command F0h handles each address bit, bit 0 first, with three slots: a read returning the bit, a read returning its complement, and a write of the master's chosen bit. When all 64 chosen bits match, `func_sel` is set.
- R7: Under F0h, a chosen bit that differs from the address bit drops the device out. All later read slots return 1 and `func_sel` stays 0 until a bus reset.
- R8: A command byte other than 33h, 55h, CCh or F0h deselects the device. Read slots return 1 and a following CCh has no effect until a bus reset.
- R9: A bus reset in the middle of any command abandons that command, and the next eight written bits are taken as a new ROM command.
- R10: `addr_crc_ok` is 1 exactly when `net_addr[63:56]` equals the CRC-8 (polynomial x^8+x^5+x^4+1, shifted in least significant bit first, starting value 00h) of `net_addr[55:0]`, bit 0 first.
- R11: The exported engine sets `crc_val` to 00h one cycle after `crc_clr`. Each `crc_shift` cycle folds `crc_din` into `crc_val` with the same polynomial and bit order as R10, and `crc_clr` takes precedence over `crc_shift`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse from the bit layer when a bus reset is detected |
| wr_stb | input | 1 | A master write slot has completed |
| wr_bit | input | 1 | The bit written in that slot |
| rd_stb | input | 1 | A master read slot is being served |
| net_addr | input | 64 | Constant network address: family code [7:0], serial [55:8], CRC [63:56] |
| tx_bit | output | 1 | Bit answered in the current read slot (1 = released) |
| func_sel | output | 1 | Device is selected; the function-command layer owns the bus |
| addr_crc_ok | output | 1 | The address check byte matches its lower 56 bits |
| crc_clr | input | 1 | Clear the shared CRC-8 engine |
| crc_shift | input | 1 | Fold `crc_din` into the engine |
| crc_din | input | 1 | Data bit for the engine |
| crc_val | output | 8 | Current engine value |

## Verification
The hardest state to reach from the ports is a drop-out in the middle of the search arbitration. The device has to have answered both the true and the complement read for a number of earlier bits, and then see a written direction that disagrees. The bench walks the three-slot pattern with the correct direction for the lower bits. At a chosen bit position it writes the complement, then keeps issuing full slot triples to show that every later read is released and that the selection never comes. A similar mid-stream mismatch is used for address matching, and a bus reset issued part-way through an address read shows that the interrupted command is abandoned.

// File: rtl/netaddr_pkg.sv
// Package netaddr_pkg
// Shared types and helpers for the net address ROM layer: FSM state
// encoding, search sub-phase, command codes and one CRC-8 step.
// Assumes a serial CRC shifted least significant bit first.
package netaddr_pkg;

    localparam int CRC_W = 8;
    // x^8+x^5+x^4+1 in reflected form for LSB-first shifting
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;

    localparam logic [7:0] CMD_READ   = 8'h33;
    localparam logic [7:0] CMD_MATCH  = 8'h55;
    localparam logic [7:0] CMD_SKIP   = 8'hCC;
    localparam logic [7:0] CMD_SEARCH = 8'hF0;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SEARCH,
        ST_SEL,
        ST_IDLE
    } rom_state_t;

    typedef enum logic [1:0] {
        SP_TRUE,
        SP_COMP,
        SP_DIR
    } search_ph_t;

    // Fold one data bit into a CRC-8 value
    function automatic logic [CRC_W-1:0] crc8_step(input logic [CRC_W-1:0] c, input logic d);
        logic fb;
        logic [CRC_W-1:0] r;
        fb = c[0] ^ d;
        r  = c >> 1;
        if (fb) r = r ^ CRC_POLY_REFL;
        return r;
    endfunction

endpackage

// File: rtl/nar_crc8_serial.sv
// Module nar_crc8_serial
// Serial CRC-8 engine shared with other layers. Clear has priority
// over shift. Assumes one data bit per enabled cycle.
module nar_crc8_serial
    import netaddr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic             din,
    output logic [CRC_W-1:0] val
);

    // Hold, clear or advance the running CRC
    always_ff @(posedge clk) begin
        if (!rst_n || clr) val <= '0;
        else if (shift)    val <= crc8_step(val, din);
    end

    // R11: a clear always leaves 00h
    a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (val == '0));

    // R11: no enable, no change
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !shift) |=> $stable(val));

endmodule

// File: rtl/nar_addr_check.sv
// Module nar_addr_check
// Combinational check that the top byte of the network address is
// the CRC-8 of the bits below it. Assumes the address is static, so
// the unrolled depth does not matter for timing.
module nar_addr_check
    import netaddr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] net_addr,
    output logic              crc_ok
);

    localparam int BODY_W = ADDR_W - CRC_W;

    logic [CRC_W-1:0] body_crc;

    // Run the CRC over the address body, bit 0 first
    always_comb begin
        body_crc = '0;
        for (int i = 0; i < BODY_W; i++) body_crc = crc8_step(body_crc, net_addr[i]);
        crc_ok = (body_crc == net_addr[ADDR_W-1 -: CRC_W]);
    end

endmodule

// File: rtl/nar_rom_fsm.sv
// Module nar_rom_fsm
// ROM command sequencer: collects the command byte, then runs address
// read, match, search arbitration or skip. It ends in a selected state
// or a deselected state that lasts until the next bus reset.
// Assumes the bit layer gives at most one strobe per cycle and samples
// tx_bit in the cycle rd_stb is high.
module nar_rom_fsm
    import netaddr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              wr_stb,
    input  logic              wr_bit,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] net_addr,
    output logic              tx_bit,
    output logic              func_sel
);

    localparam int IDX_W = $clog2(ADDR_W);
    localparam int CMD_W = 8;
    localparam int CNT_W = $clog2(CMD_W);

    rom_state_t       state;
    search_ph_t       phase;
    logic [IDX_W-1:0] idx;
    logic [CMD_W-1:0] cmd_sr;
    logic [CNT_W-1:0] cmd_cnt;
    logic [CMD_W-1:0] cmd_next;
    logic             cur_bit;
    logic             last_bit;

    assign cmd_next = {wr_bit, cmd_sr[CMD_W-1:1]};
    assign cur_bit  = net_addr[idx];
    assign last_bit = (idx == IDX_W'(ADDR_W - 1));

    // Sequence the ROM command and its address bit slots
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            state   <= ST_CMD;
            phase   <= SP_TRUE;
            idx     <= '0;
            cmd_sr  <= '0;
            cmd_cnt <= '0;
        end else begin
            case (state)
                ST_CMD: if (wr_stb) begin
                    cmd_sr  <= cmd_next;
                    cmd_cnt <= cmd_cnt + CNT_W'(1);
                    idx     <= '0;
                    phase   <= SP_TRUE;
                    if (cmd_cnt == CNT_W'(CMD_W - 1)) begin
                        case (cmd_next)
                            CMD_READ:   state <= ST_READ;
                            CMD_MATCH:  state <= ST_MATCH;
                            CMD_SEARCH: state <= ST_SEARCH;
                            CMD_SKIP:   state <= ST_SEL;
                            default:    state <= ST_IDLE;
                        endcase
                    end
                end
                ST_READ: if (rd_stb) begin
                    if (last_bit) state <= ST_SEL;
                    else          idx   <= idx + IDX_W'(1);
                end
                ST_MATCH: if (wr_stb) begin
                    if (wr_bit != cur_bit) state <= ST_IDLE;
                    else if (last_bit)     state <= ST_SEL;
                    else                   idx   <= idx + IDX_W'(1);
                end
                ST_SEARCH: begin
                    case (phase)
                        SP_TRUE: if (rd_stb) phase <= SP_COMP;
                        SP_COMP: if (rd_stb) phase <= SP_DIR;
                        default: if (wr_stb) begin
                            phase <= SP_TRUE;
                            if (wr_bit != cur_bit) state <= ST_IDLE;
                            else if (last_bit)     state <= ST_SEL;
                            else                   idx   <= idx + IDX_W'(1);
                        end
                    endcase
                end
                default: state <= state;
            endcase
        end
    end

    // Answer read slots: address bit, its complement, or release
    always_comb begin
        tx_bit = 1'b1;
        if (state == ST_READ) tx_bit = cur_bit;
        else if (state == ST_SEARCH && phase == SP_TRUE) tx_bit = cur_bit;
        else if (state == ST_SEARCH && phase == SP_COMP) tx_bit = ~cur_bit;
    end

    assign func_sel = (state == ST_SEL);

    // R1, R9: a bus reset always returns to command wait, released
    a_r9_bus_reset_returns: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (state == ST_CMD && !func_sel && tx_bit));

    // R5, R7, R8: deselection lasts until a bus reset
    a_r5_idle_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !bus_reset) |=> (state == ST_IDLE && tx_bit));

    // R2: selection lasts until a bus reset
    a_r2_sel_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel && !bus_reset) |=> func_sel);

    // R6: the search direction slot sees a released line for reads
    a_r6_dir_slot_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH && phase == SP_DIR) |-> tx_bit);

endmodule

// File: rtl/netaddr_rom_layer.sv
// Module netaddr_rom_layer
// Top of the net address ROM function layer: command sequencer,
// address check byte validator and the shared serial CRC-8 engine.
// Assumes net_addr is constant while the device runs.
module netaddr_rom_layer
    import netaddr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              wr_stb,
    input  logic              wr_bit,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] net_addr,
    output logic              tx_bit,
    output logic              func_sel,
    output logic              addr_crc_ok,
    input  logic              crc_clr,
    input  logic              crc_shift,
    input  logic              crc_din,
    output logic [CRC_W-1:0]  crc_val
);

    nar_rom_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .wr_stb    (wr_stb),
        .wr_bit    (wr_bit),
        .rd_stb    (rd_stb),
        .net_addr  (net_addr),
        .tx_bit    (tx_bit),
        .func_sel  (func_sel)
    );

    nar_addr_check #(.ADDR_W(ADDR_W)) u_chk (
        .net_addr (net_addr),
        .crc_ok   (addr_crc_ok)
    );

    nar_crc8_serial u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .shift (crc_shift),
        .din   (crc_din),
        .val   (crc_val)
    );

endmodule

// File: tb/tb_netaddr_rom_layer.sv
module tb_netaddr_rom_layer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        wr_stb = 1'b0;
    logic        wr_bit = 1'b0;
    logic        rd_stb = 1'b0;
    logic [63:0] net_addr = 64'hA200_0000_01B8_1C02;
    logic        tx_bit;
    logic        func_sel;
    logic        addr_crc_ok;
    logic        crc_clr = 1'b0;
    logic        crc_shift = 1'b0;
    logic        crc_din = 1'b0;
    logic [7:0]  crc_val;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    netaddr_rom_layer dut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .wr_stb(wr_stb), .wr_bit(wr_bit), .rd_stb(rd_stb),
        .net_addr(net_addr), .tx_bit(tx_bit), .func_sel(func_sel),
        .addr_crc_ok(addr_crc_ok), .crc_clr(crc_clr), .crc_shift(crc_shift),
        .crc_din(crc_din), .crc_val(crc_val)
    );

    function automatic logic [7:0] ref_crc(input logic [63:0] a);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic fb = c[0] ^ a[i];
            c = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic breset();
        bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic wbit(input logic b);
        wr_bit = b; wr_stb = 1'b1; @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic rbit(output logic b);
        b = tx_bit; rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wbit(v[i]);
    endtask

    task automatic t_reset();
        chk("R1 func_sel after rst_n", func_sel, 0);
        chk("R1 tx released after rst_n", tx_bit, 1);
    endtask

    task automatic t_skip();
        logic b;
        breset();
        wbyte(8'hCC);
        chk("R2 skip selects", func_sel, 1);
        rbit(b);
        chk("R2 selected line released", b, 1);
        breset();
        chk("R1 bus reset clears select", func_sel, 0);
    endtask

    task automatic t_read();
        logic [63:0] got;
        logic b;
        breset();
        wbyte(8'h33);
        for (int i = 0; i < 64; i++) begin
            if (i == 63) chk("R3 not selected before last bit", func_sel, 0);
            rbit(b); got[i] = b;
        end
        chk("R3 read address", got, net_addr);
        chk("R3 selected after read", func_sel, 1);
    endtask

    task automatic t_match_ok();
        breset();
        wbyte(8'h55);
        for (int i = 0; i < 64; i++) wbit(net_addr[i]);
        chk("R4 match selects", func_sel, 1);
    endtask

    task automatic t_match_bad(input int k);
        logic b;
        breset();
        wbyte(8'h55);
        for (int i = 0; i < 64; i++) wbit(i == k ? ~net_addr[i] : net_addr[i]);
        chk("R5 mismatch deselects", func_sel, 0);
        rbit(b);
        chk("R5 read released after mismatch", b, 1);
        wbyte(8'hCC);
        chk("R5 later writes ignored", func_sel, 0);
    endtask

    task automatic t_search(input int drop_at);
        logic t, c, b;
        int bad = 0;
        breset();
        wbyte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            rbit(t); rbit(c);
            if (drop_at < 0 || i <= drop_at) begin
                if (t !== net_addr[i] || c !== ~net_addr[i]) bad++;
            end else if (t !== 1'b1 || c !== 1'b1) bad++;
            wbit(i == drop_at ? ~net_addr[i] : net_addr[i]);
        end
        if (drop_at < 0) begin
            chk("R6 search bit/complement pairs", bad, 0);
            chk("R6 search selects", func_sel, 1);
        end else begin
            chk("R7 pairs then released reads", bad, 0);
            chk("R7 dropped out not selected", func_sel, 0);
            rbit(b);
            chk("R7 read released after drop", b, 1);
        end
    endtask

    task automatic t_unknown();
        logic b;
        breset();
        wbyte(8'hA5);
        chk("R8 unknown not selected", func_sel, 0);
        rbit(b);
        chk("R8 read released", b, 1);
        wbyte(8'hCC);
        chk("R8 skip ignored until reset", func_sel, 0);
        breset();
        wbyte(8'hCC);
        chk("R8 skip after reset selects", func_sel, 1);
    endtask

    task automatic t_abort();
        logic b;
        breset();
        wbyte(8'h33);
        for (int i = 0; i < 20; i++) rbit(b);
        breset();
        chk("R9 reset mid read released", tx_bit, 1);
        wbyte(8'hCC);
        chk("R9 new command taken", func_sel, 1);
        breset();
        wbit(1'b0); wbit(1'b0); wbit(1'b1);
        breset();
        wbyte(8'hCC);
        chk("R9 partial command discarded", func_sel, 1);
    endtask

    task automatic t_addr_crc();
        chk("R10 known good address", addr_crc_ok, 1);
        chk("R10 known crc byte", ref_crc(net_addr), 8'hA2);
        net_addr = 64'h5A00_0012_3456_7814;
        #1;
        chk("R10 other address", addr_crc_ok, (ref_crc(net_addr) == 8'h5A) ? 1 : 0);
        net_addr = {ref_crc(64'h0000_0012_3456_7814), 56'h00_0012_3456_7814};
        #1;
        chk("R10 corrected address", addr_crc_ok, 1);
        net_addr[60] = ~net_addr[60];
        #1;
        chk("R10 corrupted crc byte", addr_crc_ok, 0);
        net_addr = 64'hA200_0000_01B8_1C02;
        #1;
    endtask

    task automatic t_engine();
        crc_clr = 1'b1; crc_shift = 1'b1; crc_din = 1'b1; @(negedge clk);
        crc_clr = 1'b0; crc_shift = 1'b0;
        chk("R11 clear wins and zeroes", crc_val, 8'h00);
        for (int i = 0; i < 56; i++) begin
            crc_din = net_addr[i]; crc_shift = 1'b1; @(negedge clk);
        end
        crc_shift = 1'b0;
        chk("R11 engine over address body", crc_val, net_addr[63:56]);
        @(negedge clk);
        chk("R11 engine holds", crc_val, net_addr[63:56]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_skip();
        t_read();
        t_match_ok();
        t_match_bad(0);
        t_match_bad(37);
        t_search(-1);
        t_search(21);
        t_search(63);
        t_unknown();
        t_abort();
        t_addr_crc();
        t_engine();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule